// File: doc/BRIEF.md
# Machine Interrupt Pending and Arbitration Unit

This unit holds the machine-level interrupt enable and pending state of a small 32-bit core and decides, at each instruction boundary, whether the core must take an interrupt and with which cause. Three sources exist. The timer source is recomputed every cycle from a 64-bit counter and compare value, each split into high and low words. Two custom sources sit at indices 16 and 17: a strobe from an input port and a strobe from a message receiver. Both custom sources are sticky until software clears them.

Software changes the enable and pending registers through one CSR write port. A select input chooses the target register. Software changes the global enable through a separate strobe. The core reports instruction boundaries, entry into the wait-for-interrupt halt, trap acknowledge and return from trap. The unit answers with a trap request, a cause word and a wake signal.

A control state machine has three states. **ST_RUN** is normal execution. **ST_WAIT** means the core is halted. **ST_TRAP** means a request is outstanding. The transitions are as follows:
- *take* (ST_RUN to ST_TRAP): an instruction boundary arrives while the global enable is set and an enabled interrupt is pending.
- *halt* (ST_RUN to ST_WAIT): `wfi_enter` is asserted and *take* does not apply.
- *resume* (ST_WAIT to ST_RUN): any enabled interrupt is pending, whatever the global enable.
- *accept* (ST_TRAP to ST_RUN): `trap_ack` is asserted.

Top module: `mirq_unit`

## Requirements
- R1: After reset, the enable and pending reads, `gie`, `gie_saved`, `trap_req` and `wake` are all zero.
- R2: Only bit positions 7, 16 and 17 exist in the enable and pending registers. Every other bit reads zero, and writes to other bits have no effect.
- R3: Pending bit 7 is updated every cycle and shows in `pend_rdata` one cycle after the timer inputs change. The bit is 1 in two cases: when `tmr_cmp_hi < tmr_cnt_hi`, or when the high words are equal and `tmr_cnt_lo >= tmr_cmp_lo`. Otherwise it is 0. A software write cannot change bit 7.
- R4: A `port_evt` pulse sets pending bit 16, and a `msg_evt` pulse sets pending bit 17. Each bit is visible one cycle later and stays set until a pending write (`csr_sel`=1) clears it. When a pending write and a strobe land in the same cycle, the written value wins.
- R5: Among pending bits that are also enabled, the winner follows the fixed order 11, 3, 7, 9, 1, 5, 13, 16, 17 (highest first). `trap_cause` equals 0x80000000 plus the winner's index, so bit 7 gives 0x80000007, bit 16 gives 0x80000010 and bit 17 gives 0x80000011.
- R6: A trap is requested only if `gie` is 1 at the boundary. `trap_req` rises one cycle after a boundary that sees an enabled pending interrupt. While `gie` is 0, the pending bits keep updating and no request is made.
- R7: While `trap_req` is high, `trap_cause` holds its value. On `trap_ack`, `trap_req` drops, `gie` becomes 0 and `gie_saved` takes the previous `gie`.
- R8: A `trap_ret` pulse copies `gie_saved` into `gie` and sets `gie_saved` to 1.
- R9: In the halted state, `wake` is high whenever an enabled interrupt is pending, even with `gie` at 0. The unit then returns to normal execution on the next cycle.
- R10: A CSR write that enables an already pending source is seen by the boundary in the following cycle, so a trap can be taken before the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_cnt_hi | input | 32 | Timer counter, high word |
| tmr_cnt_lo | input | 32 | Timer counter, low word |
| tmr_cmp_hi | input | 32 | Timer compare, high word |
| tmr_cmp_lo | input | 32 | Timer compare, low word |
| port_evt | input | 1 | Input-port event strobe (bit 16) |
| msg_evt | input | 1 | Message-receive event strobe (bit 17) |
| csr_we | input | 1 | CSR write strobe |
| csr_sel | input | 1 | Write target: 0 enable register, 1 pending register |
| csr_wdata | input | 32 | CSR write value |
| gie_we | input | 1 | Global enable write strobe |
| gie_wdata | input | 1 | Global enable write value |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| wfi_enter | input | 1 | Core halts waiting for an interrupt |
| trap_ack | input | 1 | Core accepts the trap request |
| trap_ret | input | 1 | Return-from-trap strobe |
| en_rdata | output | 32 | Enable register read value |
| pend_rdata | output | 32 | Pending register read value |
| gie | output | 1 | Global machine interrupt enable |
| gie_saved | output | 1 | Saved global enable |
| trap_req | output | 1 | Trap request |
| trap_cause | output | 32 | Trap cause word |
| wake | output | 1 | Release from the wait halt |

## Verification
Timing of each result after its stimulus:
- Register writes, event strobes and timer-input changes show in `en_rdata` or `pend_rdata` one clock later.
- `trap_req` and `trap_cause` appear one clock after the boundary that sampled them.
- `gie` and `gie_saved` change one clock after `trap_ack` or `trap_ret`.
- `wake` is combinational from the pending state, so it rises in the same cycle in which the pending bit first shows.

The bench drives every input just after a falling edge and reads every result at the next falling edge. Each check therefore sits exactly one register stage after its cause. A sweep covers all enable and pending combinations of the three sources with the global enable both on and off, and computes the expected winner arithmetically.

// File: rtl/mirq_pkg.sv
package mirq_pkg;

    localparam int XLEN_DEF = 32;
    localparam int NORD     = 9;

    // Fixed arbitration order, highest priority first.
    localparam int PRIO_ORDER [NORD] = '{11, 3, 7, 9, 1, 5, 13, 16, 17};

    localparam int TMR_BIT  = 7;
    localparam int PORT_BIT = 16;
    localparam int MSG_BIT  = 17;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WAIT = 2'd1,
        ST_TRAP = 2'd2
    } ctrl_state_e;

endpackage

// File: rtl/mirq_tmr_cmp.sv
module mirq_tmr_cmp #(
    parameter int TW = 32
) (
    input  logic [TW-1:0] cnt_hi,
    input  logic [TW-1:0] cnt_lo,
    input  logic [TW-1:0] cmp_hi,
    input  logic [TW-1:0] cmp_lo,
    output logic          due
);
    logic hi_past;
    logic hi_same;
    logic lo_reached;

    always_comb begin
        hi_past    = (cmp_hi < cnt_hi);
        hi_same    = (cmp_hi == cnt_hi);
        lo_reached = (cnt_lo >= cmp_lo);
        due        = hi_past || (hi_same && lo_reached);
    end
endmodule

// File: rtl/mirq_pending.sv
module mirq_pending
    import mirq_pkg::*;
#(
    parameter int XLEN = XLEN_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tmr_due,
    input  logic            port_evt,
    input  logic            msg_evt,
    input  logic            en_we,
    input  logic            pend_we,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] en_q,
    output logic [XLEN-1:0] pend_q
);
    localparam logic [XLEN-1:0] IMPL_MASK =
        (XLEN'(1) << TMR_BIT) | (XLEN'(1) << PORT_BIT) | (XLEN'(1) << MSG_BIT);
    localparam logic [XLEN-1:0] SW_MASK =
        (XLEN'(1) << PORT_BIT) | (XLEN'(1) << MSG_BIT);

    logic [XLEN-1:0] pend_d;
    logic [XLEN-1:0] en_d;

    always_comb begin
        pend_d          = pend_q;
        pend_d[TMR_BIT] = tmr_due;
        if (port_evt) pend_d[PORT_BIT] = 1'b1;
        if (msg_evt)  pend_d[MSG_BIT]  = 1'b1;
        // Software write wins over a coinciding strobe.
        if (pend_we)  pend_d = (pend_d & ~SW_MASK) | (wdata & SW_MASK);
        pend_d = pend_d & IMPL_MASK;

        en_d = en_q;
        if (en_we) en_d = wdata & IMPL_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            en_q   <= en_d;
            pend_q <= pend_d;
        end
    end

    a_r3_timer_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (pend_q[TMR_BIT] == $past(tmr_due)));

    a_r4_port_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (port_evt && !pend_we) |=> pend_q[PORT_BIT]);

    a_r4_msg_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_evt && !pend_we) |=> pend_q[MSG_BIT]);

    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[PORT_BIT] && !pend_we) |=> pend_q[PORT_BIT]);

    a_r2_en_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        en_we |=> ((en_q & ~IMPL_MASK) == '0));
endmodule

// File: rtl/mirq_prio.sv
module mirq_prio
    import mirq_pkg::*;
#(
    parameter int XLEN = XLEN_DEF,
    localparam int IDXW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] hit,
    output logic            any,
    output logic [IDXW-1:0] idx
);
    // Scan from lowest to highest priority; the last match wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = NORD - 1; k >= 0; k--) begin
            if (hit[PRIO_ORDER[k]]) begin
                any = 1'b1;
                idx = IDXW'(PRIO_ORDER[k]);
            end
        end
    end

    always_comb begin
        if (any) begin
            a_r5_winner_is_hit: assert (hit[idx]);
        end
    end
endmodule

// File: rtl/mirq_ctrl.sv
module mirq_ctrl
    import mirq_pkg::*;
#(
    parameter int XLEN = XLEN_DEF,
    localparam int IDXW = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            insn_boundary,
    input  logic            wfi_enter,
    input  logic            trap_ack,
    input  logic            trap_ret,
    input  logic            gie_we,
    input  logic            gie_wdata,
    input  logic            irq_any,
    input  logic [IDXW-1:0] irq_idx,
    output logic            trap_req,
    output logic [XLEN-1:0] trap_cause,
    output logic            wake,
    output logic            gie,
    output logic            gie_saved
);
    ctrl_state_e     state_q, state_d;
    logic [XLEN-1:0] cause_q, cause_d;
    logic            gie_q, gie_saved_q;
    logic            take;

    always_comb begin
        take    = insn_boundary && gie_q && irq_any;
        cause_d = '0;
        cause_d[XLEN-1]   = 1'b1;
        cause_d[IDXW-1:0] = irq_idx;
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (take)           state_d = ST_TRAP;
                else if (wfi_enter) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (irq_any)        state_d = ST_RUN;
            end
            ST_TRAP: begin
                if (trap_ack)       state_d = ST_RUN;
            end
            default:                state_d = ST_RUN;
        endcase
    end

    // State register, latched cause, global enable pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_RUN;
            cause_q     <= '0;
            gie_q       <= 1'b0;
            gie_saved_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && take) cause_q <= cause_d;
            if (state_q == ST_TRAP && trap_ack) begin
                gie_q       <= 1'b0;
                gie_saved_q <= gie_q;
            end else if (trap_ret) begin
                gie_q       <= gie_saved_q;
                gie_saved_q <= 1'b1;
            end else if (gie_we) begin
                gie_q <= gie_wdata;
            end
        end
    end

    // Outputs.
    always_comb begin
        trap_req   = (state_q == ST_TRAP);
        trap_cause = trap_req ? cause_q : '0;
        wake       = (state_q == ST_WAIT) && irq_any;
        gie        = gie_q;
        gie_saved  = gie_saved_q;
    end

    a_r6_no_trap_gie_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && insn_boundary && !gie_q) |=> !trap_req);

    a_r6_take_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && insn_boundary && gie_q && irq_any) |=> trap_req);

    a_r7_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRAP && !trap_ack) |=> (trap_req && $stable(trap_cause)));

    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRAP && trap_ack) |=> (!gie_q && gie_saved_q == $past(gie_q) && !trap_req));

    a_r8_ret_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_ret && !(state_q == ST_TRAP && trap_ack)) |=> (gie_q == $past(gie_saved_q) && gie_saved_q));

    a_r9_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && irq_any) |=> (state_q == ST_RUN));
endmodule

// File: rtl/mirq_unit.sv
module mirq_unit
    import mirq_pkg::*;
#(
    parameter int XLEN = XLEN_DEF,
    parameter int TW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TW-1:0]   tmr_cnt_hi,
    input  logic [TW-1:0]   tmr_cnt_lo,
    input  logic [TW-1:0]   tmr_cmp_hi,
    input  logic [TW-1:0]   tmr_cmp_lo,
    input  logic            port_evt,
    input  logic            msg_evt,
    input  logic            csr_we,
    input  logic            csr_sel,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic            gie_we,
    input  logic            gie_wdata,
    input  logic            insn_boundary,
    input  logic            wfi_enter,
    input  logic            trap_ack,
    input  logic            trap_ret,
    output logic [XLEN-1:0] en_rdata,
    output logic [XLEN-1:0] pend_rdata,
    output logic            gie,
    output logic            gie_saved,
    output logic            trap_req,
    output logic [XLEN-1:0] trap_cause,
    output logic            wake
);
    localparam int IDXW = $clog2(XLEN);

    logic            tmr_due;
    logic [XLEN-1:0] en_q;
    logic [XLEN-1:0] pend_q;
    logic [XLEN-1:0] hit;
    logic            irq_any;
    logic [IDXW-1:0] irq_idx;

    mirq_tmr_cmp #(.TW(TW)) u_tmr (
        .cnt_hi (tmr_cnt_hi),
        .cnt_lo (tmr_cnt_lo),
        .cmp_hi (tmr_cmp_hi),
        .cmp_lo (tmr_cmp_lo),
        .due    (tmr_due)
    );

    mirq_pending #(.XLEN(XLEN)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmr_due  (tmr_due),
        .port_evt (port_evt),
        .msg_evt  (msg_evt),
        .en_we    (csr_we && !csr_sel),
        .pend_we  (csr_we && csr_sel),
        .wdata    (csr_wdata),
        .en_q     (en_q),
        .pend_q   (pend_q)
    );

    assign hit = en_q & pend_q;

    mirq_prio #(.XLEN(XLEN)) u_prio (
        .hit (hit),
        .any (irq_any),
        .idx (irq_idx)
    );

    mirq_ctrl #(.XLEN(XLEN)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .insn_boundary (insn_boundary),
        .wfi_enter     (wfi_enter),
        .trap_ack      (trap_ack),
        .trap_ret      (trap_ret),
        .gie_we        (gie_we),
        .gie_wdata     (gie_wdata),
        .irq_any       (irq_any),
        .irq_idx       (irq_idx),
        .trap_req      (trap_req),
        .trap_cause    (trap_cause),
        .wake          (wake),
        .gie           (gie),
        .gie_saved     (gie_saved)
    );

    assign en_rdata   = en_q;
    assign pend_rdata = pend_q;
endmodule

// File: tb/mirq_unit_bench.sv
`timescale 1ns/1ps
module mirq_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tmr_cnt_hi = '0, tmr_cnt_lo = '0, tmr_cmp_hi = '0, tmr_cmp_lo = 32'd1;
    logic        port_evt = 0, msg_evt = 0, csr_we = 0, csr_sel = 0;
    logic [31:0] csr_wdata = '0;
    logic        gie_we = 0, gie_wdata = 0, insn_boundary = 0, wfi_enter = 0;
    logic        trap_ack = 0, trap_ret = 0;
    logic [31:0] en_rdata, pend_rdata, trap_cause;
    logic        gie, gie_saved, trap_req, wake;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mirq_unit u_mirq_unit (
        .clk(clk), .rst_n(rst_n),
        .tmr_cnt_hi(tmr_cnt_hi), .tmr_cnt_lo(tmr_cnt_lo),
        .tmr_cmp_hi(tmr_cmp_hi), .tmr_cmp_lo(tmr_cmp_lo),
        .port_evt(port_evt), .msg_evt(msg_evt),
        .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
        .gie_we(gie_we), .gie_wdata(gie_wdata),
        .insn_boundary(insn_boundary), .wfi_enter(wfi_enter),
        .trap_ack(trap_ack), .trap_ret(trap_ret),
        .en_rdata(en_rdata), .pend_rdata(pend_rdata),
        .gie(gie), .gie_saved(gie_saved),
        .trap_req(trap_req), .trap_cause(trap_cause), .wake(wake)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expand(input int v);
        logic [31:0] r = '0;
        r[7]  = v[0];
        r[16] = v[1];
        r[17] = v[2];
        return r;
    endfunction

    task automatic nedge();
        @(negedge clk);
    endtask

    task automatic wr_csr(input logic sel, input logic [31:0] val);
        csr_we = 1; csr_sel = sel; csr_wdata = val;
        nedge();
        csr_we = 0;
    endtask

    task automatic set_timer(input logic due);
        tmr_cnt_hi = 0; tmr_cmp_hi = 0; tmr_cnt_lo = 0;
        tmr_cmp_lo = due ? 32'd0 : 32'd1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) nedge();
        rst_n = 1;
        nedge();
        // R1 reset state
        check(en_rdata, 0, "R1 en");
        check(pend_rdata, 0, "R1 pend");
        check({28'd0, gie, gie_saved, trap_req, wake}, 0, "R1 flags");

        // R2 unimplemented bits
        wr_csr(0, 32'hFFFF_FFFF);
        check(en_rdata, 32'h0003_0080, "R2 enable mask");
        wr_csr(1, 32'hFFFF_FFFF);
        check(pend_rdata, 32'h0003_0000, "R2 pending mask");
        wr_csr(0, 32'h0); wr_csr(1, 32'h0);

        // R3 timer compare corners
        tmr_cnt_hi = 5; tmr_cmp_hi = 4; tmr_cnt_lo = 0; tmr_cmp_lo = 32'hFFFF_FFFF;
        nedge(); check({31'd0, pend_rdata[7]}, 1, "R3 high below");
        tmr_cmp_hi = 5; tmr_cnt_lo = 9; tmr_cmp_lo = 9;
        nedge(); check({31'd0, pend_rdata[7]}, 1, "R3 equal reached");
        tmr_cnt_lo = 8;
        nedge(); check({31'd0, pend_rdata[7]}, 0, "R3 equal not reached");
        tmr_cmp_hi = 6; tmr_cnt_lo = 100; tmr_cmp_lo = 0;
        nedge(); check({31'd0, pend_rdata[7]}, 0, "R3 high above");
        wr_csr(1, 32'h0000_0080);
        check({31'd0, pend_rdata[7]}, 0, "R3 sw write ignored");

        // R4 events, stickiness, write priority
        port_evt = 1; nedge(); port_evt = 0;
        check(pend_rdata, 32'h0001_0000, "R4 port sets");
        repeat (3) nedge();
        check(pend_rdata, 32'h0001_0000, "R4 sticky");
        msg_evt = 1; nedge(); msg_evt = 0;
        check(pend_rdata, 32'h0003_0000, "R4 msg sets");
        msg_evt = 1; wr_csr(1, 32'h0); msg_evt = 0;
        check(pend_rdata, 32'h0, "R4 write wins");

        // R6 no trap while gie clear, pending still updates
        wr_csr(0, 32'h0001_0000);
        port_evt = 1; insn_boundary = 1; nedge(); port_evt = 0; insn_boundary = 0;
        check(pend_rdata, 32'h0001_0000, "R6 pend updates gie off");
        insn_boundary = 1; nedge(); insn_boundary = 0;
        check({31'd0, trap_req}, 0, "R6 no trap gie off");

        // R9 wake from halt with gie clear
        wr_csr(1, 32'h0);
        wfi_enter = 1; nedge(); wfi_enter = 0;
        check({31'd0, wake}, 0, "R9 no wake idle");
        port_evt = 1; nedge(); port_evt = 0;
        check({31'd0, wake}, 1, "R9 wake on enabled event");
        nedge();
        check({31'd0, wake}, 0, "R9 left halt");
        check({31'd0, trap_req}, 0, "R9 no trap gie off");

        // R10 enable write then next-cycle boundary
        gie_we = 1; gie_wdata = 1; wr_csr(0, 32'h0); gie_we = 0;
        insn_boundary = 1; nedge(); insn_boundary = 0;
        check({31'd0, trap_req}, 0, "R10 disabled no trap");
        wr_csr(0, 32'h0001_0000);
        insn_boundary = 1; nedge(); insn_boundary = 0;
        check({31'd0, trap_req}, 1, "R10 trap after enable");
        check(trap_cause, 32'h8000_0010, "R10 cause");
        trap_ack = 1; nedge(); trap_ack = 0;
        trap_ret = 1; nedge(); trap_ret = 0;

        // R5 R6 R7 R8 sweep
        for (int e = 0; e < 8; e++) begin
            for (int p = 0; p < 8; p++) begin
                for (int g = 0; g < 2; g++) begin
                    logic [31:0] hitv;
                    int          win;
                    csr_we = 1; csr_sel = 0; csr_wdata = expand(e);
                    gie_we = 1; gie_wdata = g[0];
                    set_timer(p[0]);
                    nedge();
                    gie_we = 0;
                    csr_sel = 1; csr_wdata = expand(p);
                    nedge();
                    csr_we = 0;
                    check(en_rdata, expand(e), "R2 sweep enable");
                    check(pend_rdata, expand(p), "R4 sweep pending");
                    hitv = expand(e & p);
                    win = hitv[7] ? 7 : (hitv[16] ? 16 : (hitv[17] ? 17 : -1));
                    insn_boundary = 1; nedge(); insn_boundary = 0;
                    if (g == 1 && win >= 0) begin
                        check({31'd0, trap_req}, 1, "R6 sweep trap");
                        check(trap_cause, 32'h8000_0000 | 32'(win), "R5 sweep cause");
                        nedge();
                        check(trap_cause, 32'h8000_0000 | 32'(win), "R7 cause held");
                        trap_ack = 1; nedge(); trap_ack = 0;
                        check({30'd0, gie, gie_saved}, 32'h1, "R7 ack saves gie");
                        check({31'd0, trap_req}, 0, "R7 req drops");
                        trap_ret = 1; nedge(); trap_ret = 0;
                        check({30'd0, gie, gie_saved}, 32'h3, "R8 ret restores");
                    end else begin
                        check({31'd0, trap_req}, 0, "R6 sweep no trap");
                    end
                end
            end
        end

        done = 1;
        finish_run();
    end
endmodule